// File: doc/BRIEF.md
# Packed-Pixel Raster Operation Unit

This unit takes a 32-bit source word and a 32-bit destination word. Both hold pixels packed at a size chosen at run time. It computes the word to write back. Every pixel lane is combined on its own, using one of sixteen bitwise functions or one of six arithmetic functions. A carry or borrow never passes from one lane into the next. Three write filters are then applied:

- A zero result can be made transparent.
- A replicated plane mask protects chosen bit planes.
- A rectangular XY window can keep pixels outside the window from being written.

A block-transfer engine drives one word per cycle. It supplies the X coordinate of lane 0 and the row Y of that word. The unit returns the merged word and a per-lane write-enable vector one clock later. Fetching words from memory, storing them and stepping addresses are left to the surrounding engine.

Top module: `rop_unit`

## Requirements
- R1: `psize_i` selects the pixel width: 0→1, 1→2, 2→4, 3→8, 4→16 and 5→32 bits. Codes 6 and 7 act as 32 bits. Lane j occupies bits [j·w+w−1 : j·w], with lane 0 in the least significant position.
- R2: Opcodes 0–15 are bitwise. Each result bit equals `op_i[2*s + d]`, where s and d are the source and destination bits at that position. So 12 copies the source, 6 is XOR and 10 keeps the destination.
- R3: Opcode 16 adds source and destination modulo 2^w per lane. Opcode 17 adds and saturates at 2^w−1. No carry crosses a lane boundary.
- R4: Opcode 18 gives destination minus source modulo 2^w per lane. Opcode 19 gives the same difference but clamps it at zero.
- R5: Opcode 20 gives the unsigned maximum of the two pixels and opcode 21 the unsigned minimum. Opcodes 22–31 copy the source pixel.
- R6: When `transp_en_i` is 1, a lane whose operation result is zero is not written. The zero test uses the result before the plane mask is applied.
- R7: The low w bits of `plane_mask_i` are repeated into every lane, and the upper bits are ignored. A mask bit of 1 keeps the destination bit even in a lane that is written.
- R8: When `win_en_i` is 1, lane j has X = `x_start_i` + j, computed one bit wider so it does not wrap. The lane is written only if x_min ≤ X ≤ x_max and y_min ≤ `y_i` ≤ y_max, with both bounds inclusive. When `win_en_i` is 0, no lane is clipped.
- R9: Bit j of `lane_we_o` is 1 exactly when lane j is written. Bits at or above the lane count are 0. A lane that is not written shows its destination pixel unchanged.
- R10: Outputs are registered, so the result for the inputs of one cycle appears after the next rising edge. A synchronous active-low reset clears both outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | 32 | Packed source pixels |
| dst_i | input | 32 | Packed destination pixels |
| op_i | input | 5 | Raster operation code |
| psize_i | input | 3 | Pixel size code |
| plane_mask_i | input | 32 | Plane mask; the low pixel-width bits are used |
| transp_en_i | input | 1 | Zero-result transparency enable |
| win_en_i | input | 1 | Window clipping enable |
| x_start_i | input | 16 | X coordinate of lane 0 |
| y_i | input | 16 | Y coordinate of the word |
| x_min_i | input | 16 | Window left bound, inclusive |
| x_max_i | input | 16 | Window right bound, inclusive |
| y_min_i | input | 16 | Window top bound, inclusive |
| y_max_i | input | 16 | Window bottom bound, inclusive |
| pix_o | output | 32 | Merged word to write back |
| lane_we_o | output | 32 | Per-lane write enables |

## Verification
The bench targets the following cases, each paired with how a faulty design would show it:

- **Lane-boundary carries.** Operands overflow inside a lane at 8 bpp and at 1 bpp. A design whose adder chains across lanes would corrupt the neighbouring pixel. A 16-bit carry at the aliased size code 7 shows whether that code really widens the lane to 32 bits.
- **Saturation and clamping.** Lanes hit the top and bottom rails. A design that wraps instead would return small or large values where the rail is expected.
- **Window edges.** Lanes sit one pixel inside and one pixel outside each bound, and `x_start_i` runs past 0xFFFF. A design with exclusive bounds or a wrapping X would write the wrong lanes.
- **Transparency and plane mask.** A zero lane is given transparency, and a mask carries garbage in its upper bits. A design that tests the zero after masking, or replicates the wrong mask bits, would leak writes.
- **Every size with every opcode.** All pixel sizes and opcodes are also run with random operands against a lane-by-lane model.

// File: rtl/rop_pkg.sv
// Package: shared opcode encodings for the raster operation unit.
// Assumes opcodes are 5 bits; values below 16 are bitwise truth tables.
package rop_pkg;
    localparam int unsigned OP_W = 5;
    typedef logic [OP_W-1:0] rop_op_t;

    localparam rop_op_t OP_ADD  = 5'd16;
    localparam rop_op_t OP_ADDS = 5'd17;
    localparam rop_op_t OP_SUB  = 5'd18;
    localparam rop_op_t OP_SUBS = 5'd19;
    localparam rop_op_t OP_MAX  = 5'd20;
    localparam rop_op_t OP_MIN  = 5'd21;
endpackage

// File: rtl/rop_lane_alu.sv
// Module: rop_lane_alu
// Computes the arithmetic result for one pixel lane of width PW.
// Bitwise results are produced outside and passed in as bool_i.
// Assumes unsigned pixels; opcode values 22..31 copy the source.
module rop_lane_alu
    import rop_pkg::*;
#(
    parameter int unsigned PW = 8
) (
    input  logic [PW-1:0] src_i,
    input  logic [PW-1:0] dst_i,
    input  logic [PW-1:0] bool_i,
    input  rop_op_t       op_i,
    output logic [PW-1:0] res_o
);
    logic [PW:0] sum;
    logic [PW:0] diff;

    // Lane-local sum and difference with one extra bit for carry / borrow.
    always_comb begin
        sum  = {1'b0, dst_i} + {1'b0, src_i};
        diff = {1'b0, dst_i} - {1'b0, src_i};
    end

    // Select the lane result according to the opcode.
    always_comb begin
        case (op_i)
            OP_ADD:  res_o = sum[PW-1:0];
            OP_ADDS: res_o = sum[PW] ? {PW{1'b1}} : sum[PW-1:0];
            OP_SUB:  res_o = diff[PW-1:0];
            OP_SUBS: res_o = diff[PW] ? {PW{1'b0}} : diff[PW-1:0];
            OP_MAX:  res_o = (dst_i >= src_i) ? dst_i : src_i;
            OP_MIN:  res_o = (dst_i <= src_i) ? dst_i : src_i;
            default: res_o = op_i[OP_W-1] ? src_i : bool_i;
        endcase
    end

    // Guard the rails of the saturating operations.
    always_comb begin
        if (op_i == OP_ADDS) begin
            AST_ADDS_CEIL: assert (res_o >= dst_i && res_o >= src_i); // R3
        end
        if (op_i == OP_SUBS) begin
            AST_SUBS_FLOOR: assert (res_o <= dst_i); // R4
        end
    end
endmodule

// File: rtl/rop_lane_group.sv
// Module: rop_lane_group
// Splits a DW-bit word into DW/PW lanes of one fixed pixel width.
// Each lane gets a result and a write decision (window and transparency).
// Assumes PW divides DW, and that y_ok_i already covers the row test.
module rop_lane_group
    import rop_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter int unsigned PW = 8,
    parameter int unsigned XW = 16
) (
    input  logic [DW-1:0]        src_i,
    input  logic [DW-1:0]        dst_i,
    input  logic [DW-1:0]        bool_i,
    input  rop_op_t              op_i,
    input  logic                 transp_en_i,
    input  logic                 win_en_i,
    input  logic                 y_ok_i,
    input  logic [XW-1:0]        x_start_i,
    input  logic [XW-1:0]        x_min_i,
    input  logic [XW-1:0]        x_max_i,
    output logic [DW-1:0]        res_o,
    output logic [DW/PW-1:0]     lane_ok_o,
    output logic [DW-1:0]        bit_ok_o
);
    localparam int unsigned LANES = DW / PW;
    localparam int unsigned XPW   = XW + 1;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [PW-1:0] lane_res;
        logic [XPW-1:0] xpos;
        logic           x_ok;

        rop_lane_alu #(.PW(PW)) u_alu (
            .src_i  (src_i[j*PW +: PW]),
            .dst_i  (dst_i[j*PW +: PW]),
            .bool_i (bool_i[j*PW +: PW]),
            .op_i   (op_i),
            .res_o  (lane_res)
        );

        // Lane X position without wrap, and its inclusive range test.
        always_comb begin
            xpos = {1'b0, x_start_i} + XPW'(j);
            x_ok = (xpos >= {1'b0, x_min_i}) && (xpos <= {1'b0, x_max_i});
        end

        // Combine window and transparency into the lane write decision.
        always_comb begin
            lane_ok_o[j] = (!win_en_i || (x_ok && y_ok_i)) &&
                           !(transp_en_i && (lane_res == '0));
            bit_ok_o[j*PW +: PW] = {PW{lane_ok_o[j]}};
            res_o[j*PW +: PW]    = lane_res;
        end
    end
endmodule

// File: rtl/rop_unit.sv
// Module: rop_unit (top)
// Packed-pixel raster operation unit. It builds one lane group for every
// pixel size, selects the group given by the size code, and applies the
// plane mask. The merged word and the lane enables are registered.
// Assumes DW is a power of two; size codes above log2(DW) mean DW bits.
module rop_unit
    import rop_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter int unsigned XW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [31:0]   src_i,
    input  logic [31:0]   dst_i,
    input  logic [4:0]    op_i,
    input  logic [2:0]    psize_i,
    input  logic [31:0]   plane_mask_i,
    input  logic          transp_en_i,
    input  logic          win_en_i,
    input  logic [15:0]   x_start_i,
    input  logic [15:0]   y_i,
    input  logic [15:0]   x_min_i,
    input  logic [15:0]   x_max_i,
    input  logic [15:0]   y_min_i,
    input  logic [15:0]   y_max_i,
    output logic [31:0]   pix_o,
    output logic [31:0]   lane_we_o
);
    localparam int unsigned MAX_CODE = $clog2(DW);
    localparam int unsigned SZ_N     = MAX_CODE + 1;
    localparam int unsigned SZ_W     = $clog2(SZ_N);

    logic [SZ_W-1:0] sz_eff;
    logic [DW-1:0]   bool_res;
    logic            y_ok;
    logic [DW-1:0]   res_k   [SZ_N];
    logic [DW-1:0]   bitok_k [SZ_N];
    logic [DW-1:0]   laneok_k[SZ_N];
    logic [DW-1:0]   mrep_k  [SZ_N];
    logic [DW-1:0]   lim_k   [SZ_N];
    logic [DW-1:0]   res_sel, bitok_sel, lane_sel, mask_sel, lane_lim;
    logic [DW-1:0]   keep, nxt_pix;

    // Clamp the size code so that out-of-range codes select the widest lane.
    always_comb begin
        sz_eff = (psize_i > 3'(MAX_CODE)) ? SZ_W'(MAX_CODE) : SZ_W'(psize_i);
    end

    // Bitwise operations: each opcode bit is a truth-table entry.
    always_comb begin
        for (int i = 0; i < DW; i++) begin
            bool_res[i] = op_i[{src_i[i], dst_i[i]}];
        end
    end

    // Row test, shared by every lane of the word.
    always_comb begin
        y_ok = (y_i >= y_min_i) && (y_i <= y_max_i);
    end

    for (genvar k = 0; k < SZ_N; k++) begin : g_size
        localparam int unsigned PW = 1 << k;
        logic [DW/PW-1:0] lane_ok;

        rop_lane_group #(.DW(DW), .PW(PW), .XW(XW)) u_grp (
            .src_i       (src_i),
            .dst_i       (dst_i),
            .bool_i      (bool_res),
            .op_i        (op_i),
            .transp_en_i (transp_en_i),
            .win_en_i    (win_en_i),
            .y_ok_i      (y_ok),
            .x_start_i   (x_start_i),
            .x_min_i     (x_min_i),
            .x_max_i     (x_max_i),
            .res_o       (res_k[k]),
            .lane_ok_o   (lane_ok),
            .bit_ok_o    (bitok_k[k])
        );

        // Widen lane enables; mark which enable bits exist at this size.
        always_comb begin
            laneok_k[k] = DW'(lane_ok);
            lim_k[k]    = {DW{1'b1}} >> (DW - (DW / PW));
        end

        // Replicate the low PW mask bits into every lane.
        for (genvar i = 0; i < DW; i++) begin : g_mrep
            assign mrep_k[k][i] = plane_mask_i[i % PW];
        end
    end

    // Pick the variant for the active size and merge under the masks.
    always_comb begin
        res_sel   = res_k[sz_eff];
        bitok_sel = bitok_k[sz_eff];
        lane_sel  = laneok_k[sz_eff];
        mask_sel  = mrep_k[sz_eff];
        lane_lim  = lim_k[sz_eff];
        keep      = bitok_sel & ~mask_sel;
        nxt_pix   = (res_sel & keep) | (dst_i & ~keep);
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_o     <= '0;
            lane_we_o <= '0;
        end else begin
            pix_o     <= nxt_pix;
            lane_we_o <= lane_sel;
        end
    end

    AST_MASK_KEEPS_DST: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (((pix_o ^ $past(dst_i)) & $past(mask_sel)) == '0)); // R7
    AST_WE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((lane_we_o & ~$past(lane_lim)) == '0)); // R9
    AST_IDLE_HOLDS_DST: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (lane_we_o != '0 || pix_o == $past(dst_i))); // R9
    AST_ROW_CLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (win_en_i && !y_ok) |=> (lane_we_o == '0)); // R8
endmodule

// File: tb/tb_rop_unit.sv
module tb_rop_unit;
    typedef struct packed {
        logic [31:0] src;
        logic [31:0] dst;
        logic [4:0]  op;
        logic [2:0]  sz;
        logic [31:0] mask;
        logic        tr;
        logic        wn;
        logic [15:0] xs, y, xmn, xmx, ymn, ymx;
        logic [31:0] epix;
        logic [31:0] ewe;
        logic [23:0] tag;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        // R3 lane-local wrap add, 8 bpp
        '{32'h01020304, 32'h10FF20F0, 5'd16, 3'd3, 32'h0, 1'b0, 1'b0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 32'h110123F4, 32'h0000000F, "R3"},
        // R3 saturating add
        '{32'h01020304, 32'h10FF20F0, 5'd17, 3'd3, 32'h0, 1'b0, 1'b0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 32'h11FF23F4, 32'h0000000F, "R3"},
        // R4 wrap subtract, 4 bpp
        '{32'h11111111, 32'h0123ABCD, 5'd18, 3'd2, 32'h0, 1'b0, 1'b0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 32'hF0129ABC, 32'h000000FF, "R4"},
        // R4 clamped subtract
        '{32'h11111111, 32'h0123ABCD, 5'd19, 3'd2, 32'h0, 1'b0, 1'b0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 32'h00129ABC, 32'h000000FF, "R4"},
        // R2 XOR at 32 bpp
        '{32'hFFFF0000, 32'h0F0F0F0F, 5'd6, 3'd5, 32'h0, 1'b0, 1'b0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 32'hF0F00F0F, 32'h00000001, "R2"},
        // R6 zero source lanes stay transparent
        '{32'h00AB00CD, 32'h11223344, 5'd12, 3'd3, 32'h0, 1'b1, 1'b0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 32'h11AB33CD, 32'h00000005, "R6"},
        // R7 mask low byte replicated, upper mask bits ignored
        '{32'hFFFFFFFF, 32'h00000000, 5'd12, 3'd3, 32'hABCDEF0F, 1'b0, 1'b0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 32'hF0F0F0F0, 32'h0000000F, "R7"},
        // R8 inclusive X edges
        '{32'hAAAAAAAA, 32'h55555555, 5'd12, 3'd3, 32'h0, 1'b0, 1'b1, 16'd10, 16'd5, 16'd11, 16'd12, 16'd0, 16'd9, 32'h55AAAA55, 32'h00000006, "R8"},
        // R5 unsigned max, 16 bpp
        '{32'h80000001, 32'h7FFF0002, 5'd20, 3'd4, 32'h0, 1'b0, 1'b0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 32'h80000002, 32'h00000003, "R5"},
        // R5 unsigned min
        '{32'h80000001, 32'h7FFF0002, 5'd21, 3'd4, 32'h0, 1'b0, 1'b0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 32'h7FFF0001, 32'h00000003, "R5"},
        // R1 1 bpp add is per-bit
        '{32'hF0F0F0F0, 32'hFF00FF00, 5'd16, 3'd0, 32'h0, 1'b0, 1'b0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 32'h0FF00FF0, 32'hFFFFFFFF, "R1"},
        // R1 code 7 acts as 32 bpp: carry passes bit 15
        '{32'h0000FFFF, 32'h00000001, 5'd16, 3'd7, 32'h0, 1'b0, 1'b0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 32'h00010000, 32'h00000001, "R1"},
        // R8 row outside the window
        '{32'hAAAAAAAA, 32'h55555555, 5'd12, 3'd3, 32'h0, 1'b0, 1'b1, 16'd10, 16'd20, 16'd11, 16'd12, 16'd0, 16'd9, 32'h55555555, 32'h00000000, "R8"},
        // R5 unused opcode copies source
        '{32'h12345678, 32'h00000000, 5'd25, 3'd3, 32'h0, 1'b0, 1'b0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 32'h12345678, 32'h0000000F, "R5"},
        // R8 X does not wrap past 0xFFFF
        '{32'hAAAAAAAA, 32'h55555555, 5'd12, 3'd3, 32'h0, 1'b0, 1'b1, 16'hFFFE, 16'd0, 16'd0, 16'hFFFF, 16'd0, 16'd9, 32'h5555AAAA, 32'h00000003, "R8"}
    };

    logic clk = 1'b0;
    logic rst_n;
    vec_t stim;
    logic [31:0] pix_o, lane_we_o;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rop_unit dut (
        .clk(clk), .rst_n(rst_n),
        .src_i(stim.src), .dst_i(stim.dst), .op_i(stim.op), .psize_i(stim.sz),
        .plane_mask_i(stim.mask), .transp_en_i(stim.tr), .win_en_i(stim.wn),
        .x_start_i(stim.xs), .y_i(stim.y), .x_min_i(stim.xmn), .x_max_i(stim.xmx),
        .y_min_i(stim.ymn), .y_max_i(stim.ymx),
        .pix_o(pix_o), .lane_we_o(lane_we_o)
    );

    task automatic check(input logic [31:0] epix, input logic [31:0] ewe, input string tag);
        n_cmp++;
        if (pix_o !== epix || lane_we_o !== ewe) begin
            n_bad++;
            $display("FAIL %s: pix=%h we=%h expected pix=%h we=%h", tag, pix_o, lane_we_o, epix, ewe);
        end
    endtask

    // Lane-by-lane reference written from the requirements.
    function automatic void ref_model(input vec_t v, output logic [31:0] pix, output logic [31:0] we);
        int code = (v.sz > 5) ? 5 : int'(v.sz);
        int pw = 1 << code;
        int n = 32 / pw;
        longint pm = (longint'(1) << pw) - 1;
        pix = v.dst;
        we = '0;
        for (int j = 0; j < n; j++) begin
            longint a = (longint'(v.src) >> (j * pw)) & pm;
            longint b = (longint'(v.dst) >> (j * pw)) & pm;
            longint m = longint'(v.mask) & pm;
            longint r = 0;
            bit ok = 1'b1;
            longint x = longint'(v.xs) + j;
            if (v.op < 16) begin
                for (int t = 0; t < pw; t++)
                    if (v.op[{a[t], b[t]}]) r |= (longint'(1) << t);
            end else begin
                case (int'(v.op))
                    16: r = (a + b) & pm;
                    17: r = (a + b > pm) ? pm : a + b;
                    18: r = (b - a) & pm;
                    19: r = (b > a) ? b - a : 0;
                    20: r = (a > b) ? a : b;
                    21: r = (a < b) ? a : b;
                    default: r = a;
                endcase
            end
            if (v.wn && !(x >= v.xmn && x <= v.xmx && v.y >= v.ymn && v.y <= v.ymx)) ok = 1'b0;
            if (v.tr && r == 0) ok = 1'b0;
            if (ok) begin
                we[j] = 1'b1;
                for (int t = 0; t < pw; t++)
                    pix[j * pw + t] = m[t] ? b[t] : r[t];
            end
        end
    endfunction

    function automatic string op_tag(input logic [4:0] op);
        if (op < 16) return "R2";
        if (op < 18) return "R3";
        if (op < 20) return "R4";
        return "R5";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] ep, ew;
        rst_n = 1'b0;
        stim = VECS[0];
        repeat (3) @(negedge clk);
        check(32'h0, 32'h0, "R10 reset state");
        rst_n = 1'b1;

        // Table walk: one-cycle latency per vector.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            stim = VECS[i];
            @(negedge clk);
            check(VECS[i].epix, VECS[i].ewe, string'(VECS[i].tag));
        end

        // R10 reset during operation clears the outputs.
        @(negedge clk);
        stim = VECS[0];
        @(negedge clk);
        check(32'h110123F4, 32'hF, "R10 before mid-run reset");
        rst_n = 1'b0;
        @(negedge clk);
        check(32'h0, 32'h0, "R10 mid-run reset");
        rst_n = 1'b1;

        // R1 every size code with every opcode, random operands and windows.
        for (int sz = 0; sz < 8; sz++) begin
            for (int op = 0; op < 32; op++) begin
                for (int rep = 0; rep < 3; rep++) begin
                    vec_t v;
                    v.src = $urandom;
                    v.dst = $urandom;
                    if (rep == 0) v.src = v.src & 32'h0F0F00FF;
                    v.op = 5'(op);
                    v.sz = 3'(sz);
                    v.mask = (rep == 2) ? $urandom : 32'h0;
                    v.tr = 1'($urandom);
                    v.wn = (rep != 0);
                    v.xs = 16'($urandom % 48);
                    v.xmn = 16'($urandom % 48);
                    v.xmx = v.xmn + 16'($urandom % 24);
                    v.ymn = 16'($urandom % 8);
                    v.ymx = v.ymn + 16'($urandom % 8);
                    v.y = 16'($urandom % 20);
                    v.epix = '0;
                    v.ewe = '0;
                    v.tag = "R1";
                    ref_model(v, ep, ew);
                    @(negedge clk);
                    stim = v;
                    @(negedge clk);
                    check(ep, ew, {"R1 random, ", op_tag(5'(op)), ", R6 R7 R8 R9"});
                end
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule